// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit produces the interrupt identification byte and the interrupt request line for a 16450-style serial port. Three interrupt sources feed it: the receiver's data-ready bit, a hidden transmitter-pending flag, and a modem-change flag. Each source is gated by its own enable bit. A fixed priority picks the single source that the identification byte reports.

The transmitter-pending flag is separate from the holding-register-empty bit (THRE). A data write clears it. The transmitter's hand-off of the byte sets it again. An enable write sets it whenever THRE is high. A read of the identification byte clears it, but only if that read reported the transmitter code. The same read always clears the modem-change flag. Modem-line changes are reported under the line-status code, `0x06`, and are gated by enable bit 2.

The identification byte and the request line are combinational from the current flags, the stored enables and the data-ready input. When one source is cleared, the next source in priority order shows in the same cycle. Register storage other than the enables, the serial data path and modem line sampling belong to neighbouring blocks.

Top module: `uart_irq_ident`

## Requirements
- R1: When `data_ready` is 1 and enable bit 0 is 1, `iid` is `0x04`, whatever the other sources are.
- R2: Otherwise, when the transmitter-pending flag is 1 and enable bit 1 is 1, `iid` is `0x02`. This takes precedence over the modem-change source.
- R3: Otherwise, when the modem-change flag is 1 and enable bit 2 is 1, `iid` is `0x06`. The flag is set by a `msr_event` pulse and is held while masked.
- R4: With no enabled source active, `iid` is `0x01`. `irq` is 1 exactly when `iid` differs from `0x01`.
- R5: A `thr_wr` pulse clears the transmitter-pending flag. A `tx_done` pulse sets it. When both pulse in the same cycle, the flag ends cleared.
- R6: An `ien_wr` pulse stores `ien_wdata` (bit 0 receive, bit 1 transmit, bit 2 modem) from the next cycle on. If `thre` is 1, the same pulse sets the transmitter-pending flag. If `thre` is 0, the flag is left unchanged.
- R7: An `iid_rd` pulse clears the transmitter-pending flag only when the `iid` shown during that read has low three bits equal to `0x2`. A read that shows any other code leaves the flag set.
- R8: Every `iid_rd` pulse clears the modem-change flag, including when the flag is masked. A `msr_event` in the same cycle as the read keeps the flag set.
- R9: A synchronous active-low reset clears both flags and all enables. After reset, `iid` is `0x01` and `irq` is 0, even while `data_ready` and `thre` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ien_wr | input | 1 | Enable-register write strobe |
| ien_wdata | input | 3 | Enable bits to store (0 receive, 1 transmit, 2 modem) |
| thr_wr | input | 1 | Data write to the holding register |
| tx_done | input | 1 | Byte handed off by the transmitter |
| thre | input | 1 | Holding-register-empty status |
| data_ready | input | 1 | Receiver data-ready status |
| msr_event | input | 1 | Modem-line change pulse |
| iid_rd | input | 1 | Read strobe of the identification byte |
| iid | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default three-bit enable width. That width covers every source, so all four identification codes can be reached, and every pairwise priority contest can be set up with one enable write. Same-cycle collisions are driven deliberately: a write arriving with a hand-off, and a modem change arriving with a read. Reads are also issued while a higher source masks the transmitter code, which shows whether the pending flag is consumed only by a read that actually reported it.

// File: rtl/uart_iid_pkg.sv
// Package: shared constants for the interrupt identification unit.
// Assumes an 8-bit identification byte and three interrupt sources.
package uart_iid_pkg;
    localparam int IID_W   = 8;
    localparam int SRC_N   = 3;
    // Source indices double as enable-bit positions.
    localparam int SRC_RX  = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_MS  = 2;
    localparam logic [IID_W-1:0] IID_NONE = 8'h01;
    localparam logic [IID_W-1:0] IID_RX   = 8'h04;
    localparam logic [IID_W-1:0] IID_TX   = 8'h02;
    localparam logic [IID_W-1:0] IID_MS   = 8'h06;
endpackage

// File: rtl/iid_enable_reg.sv
// Holds the per-source enable bits written by the host.
// Assumes a single-cycle write strobe; reset clears all enables.
module iid_enable_reg #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] en_q
);
    // Capture the enable byte on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= wdata;
    end
endmodule

// File: rtl/iid_flags.sv
// Keeps the hidden transmitter-pending and modem-change flags.
// Assumes all event inputs are single-cycle pulses.
// The transmitter code shown during a read must be presented on tx_shown.
module iid_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic tx_done,
    input  logic ien_wr,
    input  logic thre,
    input  logic msr_event,
    input  logic iid_rd,
    input  logic tx_shown,
    output logic pend_q,
    output logic msr_q
);
    logic pend_d;
    logic msr_d;

    // Transmit-pending next state: a data write beats a hand-off; a read consumes it last.
    always_comb begin
        pend_d = pend_q;
        if (thr_wr)                  pend_d = 1'b0;
        else if (tx_done)            pend_d = 1'b1;
        else if (ien_wr && thre)     pend_d = 1'b1;
        else if (iid_rd && tx_shown) pend_d = 1'b0;
    end

    // Modem-change next state: a new change survives a simultaneous read.
    always_comb begin
        msr_d = msr_q;
        if (msr_event)   msr_d = 1'b1;
        else if (iid_rd) msr_d = 1'b0;
    end

    // Register both flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            msr_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            msr_q  <= msr_d;
        end
    end
endmodule

// File: rtl/iid_prio.sv
// Fixed-priority encoder from enabled source requests to an identification code.
// Assumes index 0 is the highest priority; the code table comes from the package.
module iid_prio
    import uart_iid_pkg::*;
(
    input  logic [SRC_N-1:0] req,
    output logic [IID_W-1:0] code
);
    logic [IID_W-1:0] code_tab [SRC_N];

    // Build the per-source code table.
    always_comb begin
        code_tab[SRC_RX] = IID_RX;
        code_tab[SRC_TX] = IID_TX;
        code_tab[SRC_MS] = IID_MS;
    end

    // Walk from lowest to highest priority; the last active source wins.
    always_comb begin
        code = IID_NONE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) code = code_tab[i];
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identification unit: enables, hidden flags, priority encoder.
// Assumes the neighbouring register block supplies data_ready and thre as levels,
// and all access strobes as single-cycle pulses.
module uart_irq_ident
    import uart_iid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [SRC_N-1:0] ien_wdata,
    input  logic             thr_wr,
    input  logic             tx_done,
    input  logic             thre,
    input  logic             data_ready,
    input  logic             msr_event,
    input  logic             iid_rd,
    output logic [IID_W-1:0] iid,
    output logic             irq
);
    logic [SRC_N-1:0] ien_q;
    logic [SRC_N-1:0] src_raw;
    logic [SRC_N-1:0] src_req;
    logic             pend_q;
    logic             msr_q;
    logic             tx_shown;

    iid_enable_reg #(.WIDTH(SRC_N)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ien_wr),
        .wdata (ien_wdata),
        .en_q  (ien_q)
    );

    iid_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (thr_wr),
        .tx_done   (tx_done),
        .ien_wr    (ien_wr),
        .thre      (thre),
        .msr_event (msr_event),
        .iid_rd    (iid_rd),
        .tx_shown  (tx_shown),
        .pend_q    (pend_q),
        .msr_q     (msr_q)
    );

    // Gather raw source levels in priority order.
    always_comb begin
        src_raw         = '0;
        src_raw[SRC_RX] = data_ready;
        src_raw[SRC_TX] = pend_q;
        src_raw[SRC_MS] = msr_q;
    end

    // Mask each source with its enable bit.
    for (genvar g = 0; g < SRC_N; g++) begin : g_mask
        assign src_req[g] = src_raw[g] & ien_q[g];
    end

    iid_prio u_prio (
        .req  (src_req),
        .code (iid)
    );

    // A read consumes the pending flag only if it reported the transmitter code.
    assign tx_shown = (iid[2:0] == IID_TX[2:0]);
    // Request line follows any code other than "none".
    assign irq      = (iid != IID_NONE);
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker for the interrupt identification unit, attached by bind.
// Assumes it sees the top's enables and hidden flags through the bind connections.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ien_wr,
    input logic       thr_wr,
    input logic       tx_done,
    input logic       thre,
    input logic       data_ready,
    input logic       msr_event,
    input logic       iid_rd,
    input logic [7:0] iid,
    input logic       irq,
    input logic [2:0] ien_q,
    input logic       pend_q,
    input logic       msr_q
);
    // R1
    rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && ien_q[0]) |-> (iid == 8'h04));

    // R4
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid == 8'h01 || iid == 8'h02 || iid == 8'h04 || iid == 8'h06));

    // R4
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && !pend_q && !msr_q) |-> !irq);

    // R5
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !pend_q);

    // R6
    ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && thre && !thr_wr) |=> pend_q);

    // R7
    rd_tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && iid == 8'h02 && !thr_wr && !tx_done && !(ien_wr && thre)) |=> !pend_q);

    // R8
    rd_ms_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && !msr_event) |=> !msr_q);
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien_wr     (ien_wr),
    .thr_wr     (thr_wr),
    .tx_done    (tx_done),
    .thre       (thre),
    .data_ready (data_ready),
    .msr_event  (msr_event),
    .iid_rd     (iid_rd),
    .iid        (iid),
    .irq        (irq),
    .ien_q      (ien_q),
    .pend_q     (pend_q),
    .msr_q      (msr_q)
);

// File: tb/test_uart_irq_ident.sv
// Directed bench for the interrupt identification unit: one task per scenario.
module test_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ien_wr = 1'b0;
    logic [2:0] ien_wdata = 3'b000;
    logic       thr_wr = 1'b0;
    logic       tx_done = 1'b0;
    logic       thre = 1'b0;
    logic       data_ready = 1'b0;
    logic       msr_event = 1'b0;
    logic       iid_rd = 1'b0;
    logic [7:0] iid;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk        (clk),
        .rst_n      (rst_n),
        .ien_wr     (ien_wr),
        .ien_wdata  (ien_wdata),
        .thr_wr     (thr_wr),
        .tx_done    (tx_done),
        .thre       (thre),
        .data_ready (data_ready),
        .msr_event  (msr_event),
        .iid_rd     (iid_rd),
        .iid        (iid),
        .irq        (irq)
    );

    // Compare the identification byte and request line against expected values.
    task automatic check(input logic [7:0] exp_iid, input string tag);
        logic exp_irq;
        exp_irq = (exp_iid != 8'h01);
        total++;
        if (iid !== exp_iid || irq !== exp_irq) begin
            bad++;
            $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
                     tag, iid, irq, exp_iid, exp_irq);
        end
    endtask

    // Hold the strobes currently set for one clock edge, then drop them.
    task automatic tick();
        @(posedge clk);
        #1;
        ien_wr = 1'b0; thr_wr = 1'b0; tx_done = 1'b0;
        msr_event = 1'b0; iid_rd = 1'b0;
    endtask

    task automatic wr_ien(input logic [2:0] v);
        ien_wr = 1'b1; ien_wdata = v; tick();
    endtask

    task automatic rd_iid();
        iid_rd = 1'b1; tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; #1;
    endtask

    // R9: reset state with raw sources high.
    task automatic t_reset();
        data_ready = 1'b1; thre = 1'b1;
        do_reset();
        check(8'h01, "R9 reset idle");
        data_ready = 1'b0; thre = 1'b0; #1;
    endtask

    // R1, R4: receive source alone.
    task automatic t_rx();
        wr_ien(3'b001);
        data_ready = 1'b1; #1;
        check(8'h04, "R1 rx code");
        data_ready = 1'b0; #1;
        check(8'h01, "R4 none pending");
    endtask

    // R6, R2: enable write sets pending only with THRE.
    task automatic t_ien_set();
        wr_ien(3'b010);
        check(8'h01, "R6 no set without thre");
        thre = 1'b1;
        wr_ien(3'b010);
        check(8'h02, "R2 tx code after ien write");
    endtask

    // R1, R7: read under a masking receive code keeps pending.
    task automatic t_rd_masked();
        wr_ien(3'b011);
        data_ready = 1'b1; #1;
        check(8'h04, "R1 rx beats tx");
        rd_iid();
        data_ready = 1'b0; #1;
        check(8'h02, "R7 pending kept after rx read");
        rd_iid();
        check(8'h01, "R7 tx read clears pending");
    endtask

    // R5: data write and hand-off.
    task automatic t_write_handoff();
        wr_ien(3'b010);
        check(8'h02, "R5 setup pending");
        thr_wr = 1'b1; tick();
        check(8'h01, "R5 write clears");
        tx_done = 1'b1; tick();
        check(8'h02, "R5 hand-off sets");
        thr_wr = 1'b1; tx_done = 1'b1; tick();
        check(8'h01, "R5 write wins over hand-off");
    endtask

    // R3, R8: modem-change flag.
    task automatic t_modem();
        thre = 1'b0;
        wr_ien(3'b100);
        msr_event = 1'b1; tick();
        check(8'h06, "R3 modem code");
        rd_iid();
        check(8'h01, "R8 read clears modem");
        msr_event = 1'b1; iid_rd = 1'b1; tick();
        check(8'h06, "R8 event beats read");
        rd_iid();
        wr_ien(3'b000);
        msr_event = 1'b1; tick();
        check(8'h01, "R3 masked modem");
        wr_ien(3'b100);
        check(8'h06, "R3 flag held while masked");
        rd_iid();
        wr_ien(3'b000);
        msr_event = 1'b1; tick();
        rd_iid();
        wr_ien(3'b100);
        check(8'h01, "R8 masked read clears");
    endtask

    // R2: transmitter beats modem; one read clears both.
    task automatic t_tx_vs_modem();
        thre = 1'b1;
        wr_ien(3'b110);
        msr_event = 1'b1; tick();
        check(8'h02, "R2 tx beats modem");
        rd_iid();
        check(8'h01, "R7 R8 read clears both");
    endtask

    // R9: reset mid-run drops flags and enables.
    task automatic t_reset_mid();
        msr_event = 1'b1; tick();
        data_ready = 1'b1;
        do_reset();
        check(8'h01, "R9 mid-run reset");
        data_ready = 1'b0; thre = 1'b0;
        wr_ien(3'b110);
        check(8'h01, "R9 flags cleared by reset");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_rx();
        t_ien_set();
        t_rd_masked();
        t_write_handoff();
        t_modem();
        t_tx_vs_modem();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule